// File: doc/BRIEF.md
# Parallel Comparison Rank Sorter

The block sorts a group of unsigned keys into ascending order in a fixed number of cycles. It does not move keys through a compare-exchange network. Every key is compared with every other key at the same time. For each key, the number of keys it beats is counted, and that count is the key's zero-based position in the result. Each key is then written straight into the output slot named by its count. Keys of equal value are ordered by their input index, so the counts always form a permutation and every output slot receives exactly one key.

A user presents all keys on a wide parallel bus and pulses `start` for one cycle while the block is idle. The keys are captured on that edge, so the bus may change afterwards. The sorted keys appear three cycles later together with a one-cycle `done` pulse. They stay on `keys_out` until the next job completes. A `start` raised while the block is busy is dropped.

Top module: `rank_sorter`

## Requirements
- R1: While `rst_n` is low and after reset is released, `done` and `busy` are 0 and `keys_out` is all zeros until the first job completes.
- R2: On completion, slot s of `keys_out` (bits s*W +: W, slot 0 the smallest) holds the keys captured at start, in ascending unsigned order.
- R3: Key i (bits i*W +: W of `keys_in`) is placed in the slot equal to the number of keys it is strictly greater than. For example, keys 4,2,1,3 land in slots 3,1,0,2.
- R4: Equal keys are ranked by index: a key also counts each equal key of lower index. Output is then the full input multiset in ascending order, with no slot lost or duplicated.
- R5: `start` sampled high while `busy` is low is accepted. `done` is high for exactly one cycle, in the third cycle after the accepting edge's cycle, that is, 3 cycles after `start` was presented.
- R6: `busy` is high for the two cycles after an accepted `start` and low in the cycle `done` is high.
- R7: `start` sampled while `busy` is high is ignored: no extra `done` pulse occurs and the result is that of the accepted job.
- R8: `keys_out` holds its value in every cycle where `done` is low.
- R9: `keys_in` is captured only on the accepting edge; changes to it afterwards do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to sort the keys on `keys_in` |
| keys_in | input | N*W | Unsorted keys, key i at bits i*W +: W |
| busy | output | 1 | A job is in flight; `start` is ignored |
| done | output | 1 | One-cycle pulse: `keys_out` holds a new result |
| keys_out | output | N*W | Sorted keys, slot 0 smallest |

## Verification
The bench targets several inputs: already sorted, reverse-sorted, all keys equal, keys at zero and full scale, and the worked 4,2,1,3 pattern. A rank adder or tie-break fault shows up on these inputs as two keys landing in one slot and a zeroed slot beside them. The bench raises `start` again during the busy window with different keys and changes `keys_in` after acceptance. A block that re-triggered or recaptured would emit a surplus `done` or return the wrong keys. The bench also tracks the `done` cycle and the held output between jobs, which catches a pipeline with a missing or extra stage and an output register that is not gated.

// File: rtl/rank_sorter_pkg.sv
// Package: shared defaults for the rank sorter.
// Assumes: keys are unsigned and the key count is at least 2.
package rank_sorter_pkg;
    localparam int unsigned DEF_KEYS  = 8;
    localparam int unsigned DEF_KEY_W = 16;

    // Tie-break on equal keys: the higher index counts the lower one.
    function automatic logic tie_wins(input int unsigned me, input int unsigned other);
        return me > other;
    endfunction
endpackage

// File: rtl/rank_row.sv
// Module: rank_row
// Compares key IDX against every key and counts how many it outranks.
// Assumes: N >= 2; purely combinational.
module rank_row
    import rank_sorter_pkg::*;
#(
    parameter int unsigned N   = DEF_KEYS,
    parameter int unsigned W   = DEF_KEY_W,
    parameter int unsigned IDX = 0,
    localparam int unsigned RW = $clog2(N)
) (
    input  logic [N*W-1:0] keys,
    output logic [RW-1:0]  rank
);
    logic [W-1:0] mine;
    logic [RW:0]  acc;

    assign mine = keys[IDX*W +: W];

    // Sum the N comparator outputs for this key.
    always_comb begin
        acc = '0;
        for (int j = 0; j < N; j++) begin
            if ((mine > keys[j*W +: W]) ||
                ((mine == keys[j*W +: W]) && tie_wins(IDX, j)))
                acc = acc + {{RW{1'b0}}, 1'b1};
        end
    end

    assign rank = acc[RW-1:0];
endmodule

// File: rtl/rank_scatter.sv
// Module: rank_scatter
// Places each key into the output slot named by its rank.
// Assumes: ranks form a permutation of 0..N-1; combinational.
module rank_scatter #(
    parameter int unsigned N = 8,
    parameter int unsigned W = 16,
    localparam int unsigned RW = $clog2(N)
) (
    input  logic [N*W-1:0]  keys,
    input  logic [N*RW-1:0] ranks,
    output logic [N*W-1:0]  slots
);
    // Each slot ORs in the one key whose rank matches it.
    always_comb begin
        slots = '0;
        for (int s = 0; s < N; s++) begin
            for (int i = 0; i < N; i++) begin
                if (ranks[i*RW +: RW] == RW'(s))
                    slots[s*W +: W] = slots[s*W +: W] | keys[i*W +: W];
            end
        end
    end
endmodule

// File: rtl/sort_ctrl.sv
// Module: sort_ctrl
// Valid pipeline for capture, rank and scatter; drops start while busy.
// Assumes: one job in flight at a time.
module sort_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic accept,
    output logic rank_v,
    output logic scat_v,
    output logic busy,
    output logic done
);
    assign busy   = rank_v | scat_v;
    assign accept = start & ~busy;

    // Advance the job token one stage per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rank_v <= 1'b0;
            scat_v <= 1'b0;
            done   <= 1'b0;
        end else begin
            rank_v <= accept;
            scat_v <= rank_v;
            done   <= scat_v;
        end
    end
endmodule

// File: rtl/rank_sorter.sv
// Module: rank_sorter (top)
// Sorts N keys by all-pairs ranking and direct scatter, 3 cycles per job.
// Assumes: synchronous active-low reset; start ignored while busy.
module rank_sorter
    import rank_sorter_pkg::*;
#(
    parameter int unsigned N = DEF_KEYS,
    parameter int unsigned W = DEF_KEY_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [N*W-1:0] keys_in,
    output logic           busy,
    output logic           done,
    output logic [N*W-1:0] keys_out
);
    localparam int unsigned RW = $clog2(N);

    logic           accept, rank_v, scat_v;
    logic [N*W-1:0] cap_q, key2_q, slots;
    logic [N*RW-1:0] ranks, rank_q;

    sort_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .accept (accept),
        .rank_v (rank_v),
        .scat_v (scat_v),
        .busy   (busy),
        .done   (done)
    );

    for (genvar i = 0; i < N; i++) begin : g_row
        rank_row #(.N(N), .W(W), .IDX(i)) u_row (
            .keys (cap_q),
            .rank (ranks[i*RW +: RW])
        );
    end

    rank_scatter #(.N(N), .W(W)) u_scat (
        .keys  (key2_q),
        .ranks (rank_q),
        .slots (slots)
    );

    // Stage 1: capture keys on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)      cap_q <= '0;
        else if (accept) cap_q <= keys_in;
    end

    // Stage 2: register ranks with the keys they belong to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rank_q <= '0;
            key2_q <= '0;
        end else if (rank_v) begin
            rank_q <= ranks;
            key2_q <= cap_q;
        end
    end

    // Stage 3: register the scattered result.
    always_ff @(posedge clk) begin
        if (!rst_n)      keys_out <= '0;
        else if (scat_v) keys_out <= slots;
    end
endmodule

// File: rtl/rank_sorter_chk.sv
// Module: rank_sorter_chk
// Port-level properties of the sorter, bound to the top.
// Assumes: reset is held for at least one clock.
module rank_sorter_chk #(
    parameter int unsigned N = 8,
    parameter int unsigned W = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic [N*W-1:0] keys_out
);
    logic ordered;

    // Flag whether adjacent output slots are non-decreasing.
    always_comb begin
        ordered = 1'b1;
        for (int s = 0; s + 1 < N; s++)
            if (keys_out[s*W +: W] > keys_out[(s+1)*W +: W]) ordered = 1'b0;
    end

    // R2
    sorted_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ordered);
    // R5
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |-> ##3 done);
    // R5
    pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6
    busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R7
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(keys_out));
endmodule

bind rank_sorter rank_sorter_chk #(.N(N), .W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .keys_out (keys_out)
);

// File: tb/sim_rank_sorter.sv
// Scoreboard bench: driver queues expected results, monitor compares on done.
module sim_rank_sorter;
    localparam int N = 8;
    localparam int W = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [N*W-1:0] keys_in = '0;
    logic           busy, done;
    logic [N*W-1:0] keys_out;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int jobs   = 0;
    int dones  = 0;
    logic [N*W-1:0] exp_q[$];
    int             cyc_q[$];
    logic [N*W-1:0] last_out = '0;
    logic [31:0]    lfsr = 32'h1234_5678;

    rank_sorter #(.N(N), .W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .keys_in(keys_in),
        .busy(busy), .done(done), .keys_out(keys_out)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [N*W-1:0] act,
                         input logic [N*W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [N*W-1:0] ref_sort(input logic [N*W-1:0] k);
        logic [W-1:0] a[N];
        logic [N*W-1:0] r;
        for (int i = 0; i < N; i++) a[i] = k[i*W +: W];
        for (int i = 1; i < N; i++)
            for (int j = i; j > 0 && a[j-1] > a[j]; j--) begin
                logic [W-1:0] t;
                t = a[j]; a[j] = a[j-1]; a[j-1] = t;
            end
        for (int i = 0; i < N; i++) r[i*W +: W] = a[i];
        return r;
    endfunction

    function automatic logic [N*W-1:0] pack(input int v[N]);
        logic [N*W-1:0] r;
        for (int i = 0; i < N; i++) r[i*W +: W] = W'(v[i]);
        return r;
    endfunction

    // Driver: present keys, queue expectation, optionally poke start while busy.
    task automatic run(input logic [N*W-1:0] k, input bit poke);
        @(negedge clk);
        keys_in = k; start = 1'b1;
        exp_q.push_back(ref_sort(k));
        cyc_q.push_back(cyc + 3);
        jobs++;
        @(negedge clk);
        start = poke; keys_in = ~k;
        check(busy === 1'b1, "R6 busy1", {{(N*W-1){1'b0}}, busy}, 1);
        @(negedge clk);
        keys_in = k ^ {N{16'h5A5A}};
        check(busy === 1'b1, "R6 busy2", {{(N*W-1){1'b0}}, busy}, 1);
        @(negedge clk);
        start = 1'b0;
        check(done === 1'b1 && busy === 1'b0, "R5/R6 done cycle",
              {{(N*W-2){1'b0}}, done, busy}, 2);
    endtask

    // Monitor: pop and compare on each done.
    always @(negedge clk) begin
        if (rst_n && done === 1'b1) begin
            dones++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected done", keys_out, '0);
            end else begin
                logic [N*W-1:0] e;
                int ec;
                e = exp_q.pop_front();
                ec = cyc_q.pop_front();
                check(keys_out === e, "R2/R3/R4/R9 sorted result", keys_out, e);
                check(cyc == ec, "R5 latency", N*W'(cyc), N*W'(ec));
            end
            last_out = keys_out;
        end else if (rst_n && dones > 0) begin
            if (keys_out !== last_out)
                check(1'b0, "R8 hold", keys_out, last_out);
        end
    end

    // Watchdog.
    initial begin
        #1_000_000;
        check(1'b0, "watchdog", '0, '0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int ex[N]  = '{4, 2, 1, 3, 8, 7, 6, 5};
        int asc[N] = '{1, 2, 3, 4, 5, 6, 7, 8};
        int dsc[N] = '{900, 800, 700, 600, 500, 400, 300, 200};
        int eq[N]  = '{7, 7, 7, 7, 7, 7, 7, 7};
        int ext[N] = '{65535, 0, 65535, 1, 0, 65534, 32768, 32767};
        int dup[N] = '{5, 3, 5, 3, 9, 0, 9, 0};
        repeat (3) @(negedge clk);
        // R1
        check(done === 1'b0 && busy === 1'b0 && keys_out === '0, "R1 in reset",
              keys_out, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done === 1'b0 && busy === 1'b0 && keys_out === '0, "R1 after reset",
              keys_out, '0);
        run(pack(ex), 1'b0);   // R3 worked example
        run(pack(asc), 1'b0);
        run(pack(dsc), 1'b1);  // R7 start while busy
        run(pack(eq), 1'b0);   // R4 all equal
        run(pack(ext), 1'b1);  // R4/R7 extremes with duplicates
        run(pack(dup), 1'b0);  // R4 pairs
        for (int t = 0; t < 6; t++) begin
            logic [N*W-1:0] k;
            for (int i = 0; i < N; i++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                k[i*W +: W] = lfsr[W-1:0];
            end
            run(k, t[0]);
        end
        repeat (5) @(negedge clk);
        // R8 result still held after idle cycles
        check(keys_out === last_out, "R8 idle hold", keys_out, last_out);
        // R7 one done per accepted job
        check(dones == jobs && exp_q.size() == 0, "R7 done count",
              N*W'(dones), N*W'(jobs));
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule